// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers 37 level-sensitive interrupt source lines. Each source line sets its own sticky pending bit. A per-source enable mask then selects which pending bits take part. From the pending, enabled set the block produces three outputs: a normal interrupt request to the processor, a separate machine-check request, and a 6-bit code that names the winning source. Two sources are routed to the machine-check output instead of the normal request: source 0, the watchdog event, and source 1, the event on external line 0.

Priority is configurable at run time. Software can name one source as the promoted source, and that source beats every other source. Sources 8 to 19 form three communication-controller groups of four: A is 8 to 11, B is 12 to 15 and C is 16 to 19. The order of these three groups can be rotated. All other sources keep a fixed order in which a lower index means a higher priority.

Software reaches the block through a word-wide register bus with a registered read. Pending bits are cleared by writing a 1 to them.

Top module: `prio_intc`

## Requirements
- R1: A source line that is high at a rising clock edge sets its pending bit at that edge. The bit stays set after the line falls.
- R2: A bus write to a pending word (address 0 holds sources 0-31 in bits 31:0; address 1 holds sources 32-36 in bits 4:0) clears each pending bit that is written with 1. Bits written with 0 keep their value.
- R3: When a source line is high in the same cycle as a clear of its pending bit, the bit stays set.
- R4: A pending source whose enable bit is 0 affects neither the request outputs nor the vector. The enable bits are written at address 2 (sources 0-31) and address 3 (sources 32-36), and a value of 1 enables the source.
- R5: `irq_o` is 1 exactly when some pending, enabled source other than sources 0 and 1 exists. It is registered, so it follows the pending and enable state with one clock of delay.
- R6: `mcp_o` is 1 exactly when source 0 or source 1 is pending and enabled. It uses the same one-clock delay.
- R7: `vec_o` carries code i+1 for the highest-priority pending, enabled source i, one clock after the state changes. It is 0 when no such source exists. Sources 0 and 1 also take part in the vector. In the default order, a lower index wins.
- R8: The configuration register at address 4 holds the promoted source code in bits 5:0. If that code lies in 1..37 and its source is pending and enabled, the vector shows that code whatever else is pending. A code of 0 or a code above 37 promotes no source.
- R9: Bits 9:8 of address 4 select the order of the groups, from highest to lowest. 0 gives A,B,C; 1 gives B,C,A; 2 gives C,A,B. Inside each group, a lower index wins.
- R10: The reserved value 3 in bits 9:8 gives the default order A,B,C.
- R11: A read returns the addressed register one clock after the address is presented. Address 5 returns the current vector in bits 5:0. Unused bits read as 0.
- R12: After reset, all pending bits, enable bits, configuration fields and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 37 | Level source lines, one bit per source |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| mcp_o | output | 1 | Machine-check request |
| vec_o | output | 6 | Code of the winning source, or 0 when none |

## Verification
Some properties are checked on every cycle. After any high source line, the matching pending bit must be set on the next cycle, even when a clear is written in that cycle. Each request output must match the enabled pending set of one cycle earlier. The vector must be zero exactly when that set was empty. A promoted source that is pending and enabled must be the one reported.

Other behaviour can only be shown by the bench's scenarios. These scenarios cover the full ordering among competing sources under each group-order encoding, including the reserved one. They also cover write-one-to-clear with mixed 0 and 1 data, and readback through the bus.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ADDR_PEND_LO = 3'd0,
    ADDR_PEND_HI = 3'd1,
    ADDR_EN_LO   = 3'd2,
    ADDR_EN_HI   = 3'd3,
    ADDR_CFG     = 3'd4,
    ADDR_VEC     = 3'd5
  } pic_addr_e;

  // Slot (0 = highest) taken by group g under a group-order setting.
  function automatic int unsigned grp_slot(input int unsigned g, input logic [1:0] ord);
    case (ord)
      2'd1:    return (g + 2) % 3;
      2'd2:    return (g + 1) % 3;
      default: return g;
    endcase
  endfunction
endpackage

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int NSRC = 37
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | src;
  end
endmodule

// File: rtl/pic_rank_sel.sv
module pic_rank_sel
  import pic_pkg::*;
#(
  parameter int NSRC     = 37,
  parameter int VW       = 6,
  parameter int GRP_BASE = 8,
  parameter int GRP_SIZE = 4
) (
  input  logic [NSRC-1:0] active,
  input  logic [VW-1:0]   promo,
  input  logic [1:0]      order,
  output logic [VW-1:0]   win
);
  localparam int RW      = $clog2(NSRC + 2);
  localparam int GRP_END = GRP_BASE + 3 * GRP_SIZE;

  logic [RW-1:0] rank [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_rank
    if (i >= GRP_BASE && i < GRP_END) begin : g_grp
      localparam int G = (i - GRP_BASE) / GRP_SIZE;
      localparam int P = (i - GRP_BASE) % GRP_SIZE;
      always_comb begin
        if (promo == VW'(i + 1)) rank[i] = '0;
        else rank[i] = RW'(GRP_BASE + grp_slot(G, order) * GRP_SIZE + P + 1);
      end
    end else begin : g_fix
      always_comb begin
        if (promo == VW'(i + 1)) rank[i] = '0;
        else rank[i] = RW'(i + 1);
      end
    end
  end

  logic [RW-1:0] best;
  always_comb begin
    best = '1;
    win  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && rank[i] < best) begin
        best = rank[i];
        win  = VW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NSRC = 37,
  parameter int VW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [31:0]     wdata,
  input  logic [NSRC-1:0] pend,
  input  logic [VW-1:0]   vec,
  output logic [NSRC-1:0] en,
  output logic [VW-1:0]   promo,
  output logic [1:0]      order,
  output logic [NSRC-1:0] clr,
  output logic [31:0]     rdata
);
  localparam int PAD = 64 - NSRC;

  logic [63:0] pend_w, en_w, clr_w, en_nxt;

  assign pend_w = {{PAD{1'b0}}, pend};
  assign en_w   = {{PAD{1'b0}}, en};

  always_comb begin
    clr_w  = '0;
    en_nxt = en_w;
    if (we) begin
      case (addr)
        ADDR_PEND_LO: clr_w[31:0]   = wdata;
        ADDR_PEND_HI: clr_w[63:32]  = wdata;
        ADDR_EN_LO:   en_nxt[31:0]  = wdata;
        ADDR_EN_HI:   en_nxt[63:32] = wdata;
        default: ;
      endcase
    end
  end

  assign clr = clr_w[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      promo <= '0;
      order <= '0;
      rdata <= '0;
    end else begin
      en <= en_nxt[NSRC-1:0];
      if (we && addr == ADDR_CFG) begin
        promo <= wdata[VW-1:0];
        order <= wdata[9:8];
      end
      case (addr)
        ADDR_PEND_LO: rdata <= pend_w[31:0];
        ADDR_PEND_HI: rdata <= pend_w[63:32];
        ADDR_EN_LO:   rdata <= en_w[31:0];
        ADDR_EN_HI:   rdata <= en_w[63:32];
        ADDR_CFG:     rdata <= {22'b0, order, 2'b0, promo};
        ADDR_VEC:     rdata <= {{(32-VW){1'b0}}, vec};
        default:      rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC     = 37,
  parameter int VW       = 6,
  parameter int GRP_BASE = 8,
  parameter int GRP_SIZE = 4,
  parameter int WDOG_IDX = 0,
  parameter int XL0_IDX  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            mcp_o,
  output logic [VW-1:0]   vec_o
);
  localparam logic [NSRC-1:0] MC_SET =
    (NSRC'(1) << WDOG_IDX) | (NSRC'(1) << XL0_IDX);

  logic [NSRC-1:0] pend, en, clr, active;
  logic [VW-1:0]   promo, win;
  logic [1:0]      order;

  pic_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .src(src_i), .clr(clr), .pend(pend)
  );

  pic_regs #(.NSRC(NSRC), .VW(VW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pend(pend), .vec(vec_o), .en(en), .promo(promo), .order(order),
    .clr(clr), .rdata(bus_rdata)
  );

  assign active = pend & en;

  pic_rank_sel #(
    .NSRC(NSRC), .VW(VW), .GRP_BASE(GRP_BASE), .GRP_SIZE(GRP_SIZE)
  ) u_sel (
    .active(active), .promo(promo), .order(order), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      mcp_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= |(active & ~MC_SET);
      mcp_o <= |(active & MC_SET);
      vec_o <= win;
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NSRC = 37,
  parameter int VW   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en,
  input logic [VW-1:0]   promo,
  input logic            irq_o,
  input logic            mcp_o,
  input logic [VW-1:0]   vec_o
);
  logic [NSRC-1:0] act_c;
  logic            promo_hit;
  assign act_c = pend & en;
  assign promo_hit = (promo != '0) && (int'(promo) <= NSRC) && act_c[int'(promo) - 1];

  // R1 and R3: a high line always leaves its pending bit set.
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (|src_i) |=> ((pend & $past(src_i)) == $past(src_i)));

  assert_irq_track_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(act_c & ~NSRC'(3))));

  assert_mcp_track_R6: assert property (@(posedge clk) disable iff (rst)
    mcp_o == $past(|(act_c & NSRC'(3))));

  assert_vec_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_o == '0) == ($past(act_c) == '0));

  assert_promo_wins_R8: assert property (@(posedge clk) disable iff (rst)
    promo_hit |=> (vec_o == $past(promo)));
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .pend(pend), .en(en), .promo(promo),
  .irq_o(irq_o), .mcp_o(mcp_o), .vec_o(vec_o)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int NSRC = 37;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic            bus_we = 1'b0;
  logic [2:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_o, mcp_o;
  logic [5:0]      vec_o;

  int checks = 0;
  int errors = 0;

  logic [NSRC-1:0] m_pend = '0, m_en = '0;
  logic [5:0]      m_promo = '0;
  logic [1:0]      m_order = '0;

  always #5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .mcp_o(mcp_o),
    .vec_o(vec_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_vec();
    int grp [3];
    logic [NSRC-1:0] a;
    a = m_pend & m_en;
    if (m_promo >= 1 && m_promo <= NSRC && a[m_promo - 1]) return int'(m_promo);
    for (int i = 0; i < 8; i++) if (a[i]) return i + 1;
    case (m_order)
      2'd1:    grp = '{1, 2, 0};
      2'd2:    grp = '{2, 0, 1};
      default: grp = '{0, 1, 2};
    endcase
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 4; p++)
        if (a[8 + grp[s] * 4 + p]) return 8 + grp[s] * 4 + p + 1;
    for (int i = 20; i < NSRC; i++) if (a[i]) return i + 1;
    return 0;
  endfunction

  // Drive for one clock starting from a falling edge; update the model for that edge.
  task automatic step(input logic [NSRC-1:0] s, input logic we, input logic [2:0] a,
                      input logic [31:0] d);
    logic [63:0] c;
    src_i = s; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    c = '0;
    if (we && a == 3'd0) c[31:0] = d;
    if (we && a == 3'd1) c[63:32] = d;
    m_pend = (m_pend & ~c[NSRC-1:0]) | s;
    if (we && a == 3'd2) m_en[31:0] = d;
    if (we && a == 3'd3) m_en[NSRC-1:32] = d[NSRC-33:0];
    if (we && a == 3'd4) begin m_promo = d[5:0]; m_order = d[9:8]; end
    src_i = '0; bus_we = 1'b0;
  endtask

  task automatic check_outs(input string ctx);
    logic [NSRC-1:0] a;
    @(negedge clk);
    a = m_pend & m_en;
    chk({"R7 vec ", ctx}, 64'(vec_o), 64'(exp_vec()));
    chk({"R5 irq ", ctx}, 64'(irq_o), 64'(|(a & ~NSRC'(3))));
    chk({"R6 mcp ", ctx}, 64'(mcp_o), 64'(|(a & NSRC'(3))));
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 vec", 64'(vec_o), 0);
    chk("R12 irq", 64'(irq_o), 0);
    chk("R12 mcp", 64'(mcp_o), 0);
    rd(3'd0, d); chk("R12 pend lo", 64'(d), 0);
    rd(3'd2, d); chk("R12 en lo", 64'(d), 0);
    rd(3'd4, d); chk("R12 cfg", 64'(d), 0);

    // R4 masked source: pending but silent; R1 sticky pending
    step(NSRC'(1) << 5, 1'b0, 3'd0, 0);
    check_outs("R4 masked");
    rd(3'd0, d); chk("R1 pend sticky", 64'(d), 64'(32'h20));

    // enable all: R7 vector, R5 irq
    step('0, 1'b1, 3'd2, 32'hFFFF_FFFF);
    step('0, 1'b1, 3'd3, 32'h1F);
    check_outs("all enabled");
    chk("R7 vec src5", 64'(vec_o), 6);

    // R6 watchdog source goes to machine check
    step(NSRC'(1), 1'b0, 3'd0, 0);
    check_outs("R6 wdog");
    chk("R6 mcp on", 64'(mcp_o), 1);
    chk("R7 vec wdog", 64'(vec_o), 1);

    // R2 write of 0 has no effect, write of 1 clears
    step('0, 1'b1, 3'd0, 32'h0);
    rd(3'd0, d); chk("R2 zero write", 64'(d), 64'(32'h21));
    step('0, 1'b1, 3'd0, 32'h1);
    rd(3'd0, d); chk("R2 clear bit0", 64'(d), 64'(32'h20));
    check_outs("R2 after clear");

    // R3 set wins against clear
    step(NSRC'(1) << 5, 1'b1, 3'd0, 32'h20);
    rd(3'd0, d); chk("R3 set wins", 64'(d), 64'(32'h20));

    // R8 promotion of source code 37 (index 36) over source 5
    step(NSRC'(1) << 36, 1'b0, 3'd0, 0);
    step('0, 1'b1, 3'd4, 32'd37);
    check_outs("R8 promo");
    chk("R8 promo vec", 64'(vec_o), 37);
    step('0, 1'b1, 3'd4, 32'd45);
    check_outs("R8 out of range");
    chk("R8 none promoted", 64'(vec_o), 6);

    // R9/R10 group order with one source in each group
    step('0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    step('0, 1'b1, 3'd1, 32'h1F);
    step((NSRC'(1) << 8) | (NSRC'(1) << 13) | (NSRC'(1) << 18), 1'b0, 3'd0, 0);
    step('0, 1'b1, 3'd4, 32'h000);
    check_outs("R9 order0"); chk("R9 order0 A", 64'(vec_o), 9);
    step('0, 1'b1, 3'd4, 32'h100);
    check_outs("R9 order1"); chk("R9 order1 B", 64'(vec_o), 14);
    step('0, 1'b1, 3'd4, 32'h200);
    check_outs("R9 order2"); chk("R9 order2 C", 64'(vec_o), 19);
    step('0, 1'b1, 3'd4, 32'h300);
    check_outs("R10 reserved"); chk("R10 default A", 64'(vec_o), 9);

    // R11 readback of configuration and vector
    step('0, 1'b1, 3'd4, 32'h0000_0115);
    rd(3'd4, d); chk("R11 cfg read", 64'(d), 64'(32'h115));
    @(negedge clk);
    rd(3'd5, d); chk("R11 vec read", 64'(d), 64'(exp_vec()));

    // randomized mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      case ($urandom % 5)
        0, 1: step(NSRC'(r & {$urandom, $urandom} & {$urandom, $urandom}), 1'b0, 3'd0, 0);
        2: step(NSRC'(r[63:32] & $urandom), 1'b1, 3'($urandom % 2), r[31:0]);
        3: step('0, 1'b1, 3'(2 + $urandom % 2), r[31:0]);
        default: step(NSRC'(r[40:4] & {$urandom, $urandom}), 1'b1, 3'd4,
                      {22'b0, 2'($urandom), 2'b0, 6'($urandom % 42)});
      endcase
      check_outs("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule